// File: doc/BRIEF.md
# Token-Passing Sparsified Pixel Readout

This block is the digital readout controller for a square pixel matrix of 64 rows and 64 columns. It keeps one hit flag per pixel, together with the time stamp that was current when the hit came in and an 8-bit amplitude word. Hits arrive as digital strobes that carry a row, a column and an amplitude. A free-running 5-bit counter produces the time stamps. Its output is the bitwise complement of the reflected Gray code of the binary count, so exactly one bit changes on each clock.

A readout frame begins with a start pulse. A token then walks the pixels in raster order, with the column index changing fastest. An empty pixel passes the token on within one clock. A pixel holding a hit keeps the token until its record has been accepted on a valid/ready stream. Each record is one word that holds the row, column, time stamp and amplitude. Accepting the word clears the pixel's flag. When the token leaves the last pixel, a one-cycle done pulse marks the end of the frame. While a frame is running, new hits and injection pulses are ignored, so that each frame describes one consistent picture.

For testing, a 4096-bit serial shift register holds an injection mask, with one bit per pixel. The register can be read back through its serial output. An injection pulse marks every masked pixel as hit, and all of those pixels share the time stamp of the pulse and a supplied amplitude.

Top module: `pix_token_readout`

## Requirements
- R1: While reset is held and right after it, busy, done and out_valid are low and ts_now reads 5'b11111, which is the inverted Gray code of count 0.
- R2: ts_now advances once per clock. Decoded back to binary (invert the bits, then convert Gray to binary), consecutive values differ by exactly +1 modulo 32, and exactly one bit changes each clock.
- R3: A hit strobe accepted while idle records the ts_now value present in the cycle of the strobe, together with hit_amp.
- R4: out_word is {row[5:0], col[5:0], tstamp[4:0], amp[7:0]}, so the row occupies bits 24:19, the column 18:13, the time stamp 12:8 and the amplitude 7:0.
- R5: The token visits pixels in raster order, with the column fastest. Each empty pixel takes one clock. For a frame with no hits, done pulses for one cycle 4096 clock edges after the edge that samples start.
- R6: While a hit pixel holds the token and out_ready is low, out_valid stays high and out_word stays unchanged.
- R7: A pixel's flag clears on the edge where its word is accepted (out_valid and out_ready both high), so a later frame does not report that pixel again.
- R8: Hit strobes and injection pulses that arrive while busy is high have no effect on any pixel.
- R9: A strobe aimed at a pixel that already holds a hit is ignored, and the first time stamp and amplitude are kept.
- R10: When shift_en is high, shift_in enters bit 0 of the mask and every bit moves up by one. shift_out is bit 4095. After 4096 shifts, the first bit that was shifted in appears first at shift_out. The mask holds its value when shift_en is low.
- R11: An injection pulse accepted while idle marks as hit every pixel whose mask bit (bit index = row*64 + col) is set. Each of those pixels reports the ts_now value of the pulse cycle and the amplitude from inj_amp.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| hit_stb | input | 1 | Hit strobe for one pixel |
| hit_row | input | 6 | Row of the strobed pixel |
| hit_col | input | 6 | Column of the strobed pixel |
| hit_amp | input | 8 | Amplitude stored with the hit |
| inj_pulse | input | 1 | Test pulse that marks all masked pixels as hit |
| inj_amp | input | 8 | Amplitude given to injected hits |
| shift_en | input | 1 | Shift enable for the injection mask |
| shift_in | input | 1 | Serial mask data in |
| shift_out | output | 1 | Serial mask data out (top bit) |
| start | input | 1 | Starts a readout frame when idle |
| busy | output | 1 | High while a frame runs |
| done | output | 1 | One-cycle pulse at the end of a frame |
| out_valid | output | 1 | A record is offered |
| out_ready | input | 1 | The sink accepts the record |
| out_word | output | 25 | {row, col, tstamp, amp} |
| ts_now | output | 5 | Current inverted Gray time stamp |

## Verification
The bench measures the exact length of an empty frame. A design that stalls on empty pixels, or that wraps the pointer early, would return the wrong edge count. It holds out_ready low on a hit pixel; a design that passed the token too early would drop the record or change the word while it is still offered. It sends strobes and an injection pulse into a running frame, and a second strobe into a pixel that is already hit. A design that let these through would report extra pixels or overwrite the first stamp. The bench also decodes every time stamp back to binary, so that a plain or mis-inverted Gray sequence is caught, and it reads the mask back serially to catch a wrong shift direction.

// File: rtl/pxro_pkg.sv
package pxro_pkg;

   typedef enum logic {
      SCAN_IDLE = 1'b0,
      SCAN_RUN  = 1'b1
   } scan_state_t;

endpackage

// File: rtl/pxro_stamp.sv
module pxro_stamp #(
   parameter int TSW    = 5,
   parameter bit INVERT = 1'b1
) (
   input  logic           clk,
   input  logic           rst,
   output logic [TSW-1:0] ts
);

   logic [TSW-1:0] bin_q;
   logic [TSW-1:0] gray;

   always_ff @(posedge clk) begin
      if (rst) bin_q <= '0;
      else     bin_q <= bin_q + TSW'(1);
   end

   assign gray = bin_q ^ (bin_q >> 1);

   generate
      if (INVERT) begin : g_inv
         assign ts = ~gray;
      end else begin : g_plain
         assign ts = gray;
      end
   endgenerate

   AST_STAMP_ONE_BIT: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) |-> $countones(ts ^ $past(ts)) == 1); // R2

endmodule

// File: rtl/pxro_mask.sv
module pxro_mask #(
   parameter int NBIT = 4096
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            shift_en,
   input  logic            shift_in,
   output logic [NBIT-1:0] mask,
   output logic            shift_out
);

   always_ff @(posedge clk) begin
      if (rst)           mask <= '0;
      else if (shift_en) mask <= {mask[NBIT-2:0], shift_in};
   end

   assign shift_out = mask[NBIT-1];

   AST_MASK_HOLD: assert property (@(posedge clk) disable iff (rst)
      !shift_en |=> $stable(mask)); // R10
   AST_MASK_FEED: assert property (@(posedge clk) disable iff (rst)
      shift_en |=> mask[0] == $past(shift_in)); // R10

endmodule

// File: rtl/pxro_store.sv
module pxro_store #(
   parameter int NPIX = 4096,
   parameter int AW   = 12,
   parameter int TSW  = 5,
   parameter int AMPW = 8
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            accept_en,
   input  logic            hit_stb,
   input  logic [AW-1:0]   hit_idx,
   input  logic [AMPW-1:0] hit_amp,
   input  logic [TSW-1:0]  ts,
   input  logic            inj_pulse,
   input  logic [AMPW-1:0] inj_amp,
   input  logic [NPIX-1:0] mask,
   input  logic [AW-1:0]   rd_idx,
   input  logic            rd_clr,
   output logic            rd_hit,
   output logic [TSW-1:0]  rd_ts,
   output logic [AMPW-1:0] rd_amp
);

   localparam logic [NPIX-1:0] ONE = {{(NPIX-1){1'b0}}, 1'b1};

   logic [NPIX-1:0] hit_q, inj_q;
   logic [NPIX-1:0] stb_vec, inj_vec, clr_vec;
   logic [TSW-1:0]  ts_mem  [NPIX];
   logic [AMPW-1:0] amp_mem [NPIX];
   logic [TSW-1:0]  inj_ts_q;
   logic [AMPW-1:0] inj_amp_q;
   logic            new_one, inj_ok;

   assign new_one = hit_stb && accept_en && !hit_q[hit_idx];
   assign inj_ok  = inj_pulse && accept_en;
   assign stb_vec = new_one ? (ONE << hit_idx) : '0;
   assign inj_vec = inj_ok ? (mask & ~hit_q & ~stb_vec) : '0;
   assign clr_vec = rd_clr ? (ONE << rd_idx) : '0;

   always_ff @(posedge clk) begin
      if (rst) begin
         hit_q     <= '0;
         inj_q     <= '0;
         inj_ts_q  <= '0;
         inj_amp_q <= '0;
      end else begin
         hit_q <= (hit_q | stb_vec | inj_vec) & ~clr_vec;
         inj_q <= (inj_q | inj_vec) & ~clr_vec;
         if (inj_ok) begin
            inj_ts_q  <= ts;
            inj_amp_q <= inj_amp;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (new_one) begin
         ts_mem[hit_idx]  <= ts;
         amp_mem[hit_idx] <= hit_amp;
      end
   end

   assign rd_hit = hit_q[rd_idx];
   assign rd_ts  = inj_q[rd_idx] ? inj_ts_q  : ts_mem[rd_idx];
   assign rd_amp = inj_q[rd_idx] ? inj_amp_q : amp_mem[rd_idx];

   AST_BUSY_NO_NEW_HIT: assert property (@(posedge clk) disable iff (rst)
      !accept_en |=> (hit_q & ~$past(hit_q)) == '0); // R8
   AST_CLEAR_ON_ACCEPT: assert property (@(posedge clk) disable iff (rst)
      rd_clr |=> !hit_q[$past(rd_idx)]); // R7
   AST_CLEAR_ONLY_HIT: assert property (@(posedge clk) disable iff (rst)
      rd_clr |-> rd_hit); // R7

endmodule

// File: rtl/pxro_scan.sv
module pxro_scan
   import pxro_pkg::*;
#(
   parameter int NPIX = 4096,
   parameter int AW   = 12
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          start,
   input  logic          cur_hit,
   input  logic          out_ready,
   output logic [AW-1:0] ptr,
   output logic          busy,
   output logic          out_valid,
   output logic          clr,
   output logic          done
);

   scan_state_t   state_q;
   logic [AW-1:0] ptr_q;
   logic          done_q, run, step, last;

   assign run       = (state_q == SCAN_RUN);
   assign out_valid = run && cur_hit;
   assign step      = run && (!cur_hit || out_ready);
   assign clr       = out_valid && out_ready;
   assign last      = (ptr_q == AW'(NPIX - 1));

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q <= SCAN_IDLE;
         ptr_q   <= '0;
         done_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         unique case (state_q)
            SCAN_IDLE: begin
               if (start) begin
                  state_q <= SCAN_RUN;
                  ptr_q   <= '0;
               end
            end
            SCAN_RUN: begin
               if (step) begin
                  if (last) begin
                     state_q <= SCAN_IDLE;
                     done_q  <= 1'b1;
                  end else begin
                     ptr_q <= ptr_q + AW'(1);
                  end
               end
            end
            default: state_q <= SCAN_IDLE;
         endcase
      end
   end

   assign ptr  = ptr_q;
   assign busy = run;
   assign done = done_q;

   AST_TOKEN_HOLD: assert property (@(posedge clk) disable iff (rst)
      out_valid && !out_ready |=> out_valid && $stable(ptr_q)); // R6
   AST_SKIP_EMPTY: assert property (@(posedge clk) disable iff (rst)
      run && !cur_hit && !last |=> ptr_q == $past(ptr_q) + AW'(1)); // R5
   AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
      done |-> !busy); // R5

endmodule

// File: rtl/pix_token_readout.sv
module pix_token_readout #(
   parameter int ROWS      = 64,
   parameter int COLS      = 64,
   parameter int TSW       = 5,
   parameter int AMPW      = 8,
   parameter bit TS_INVERT = 1'b1,
   localparam int RAW  = $clog2(ROWS),
   localparam int CAW  = $clog2(COLS),
   localparam int AW   = RAW + CAW,
   localparam int NPIX = ROWS * COLS,
   localparam int WW   = AW + TSW + AMPW
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            hit_stb,
   input  logic [RAW-1:0]  hit_row,
   input  logic [CAW-1:0]  hit_col,
   input  logic [AMPW-1:0] hit_amp,
   input  logic            inj_pulse,
   input  logic [AMPW-1:0] inj_amp,
   input  logic            shift_en,
   input  logic            shift_in,
   output logic            shift_out,
   input  logic            start,
   output logic            busy,
   output logic            done,
   output logic            out_valid,
   input  logic            out_ready,
   output logic [WW-1:0]   out_word,
   output logic [TSW-1:0]  ts_now
);

   generate
      if (ROWS != (1 << RAW) || COLS != (1 << CAW) || ROWS < 2 || COLS < 2) begin : g_bad_dim
         $error("pix_token_readout: ROWS and COLS must be powers of two, at least 2");
      end
      if (TSW < 2 || AMPW < 1) begin : g_bad_width
         $error("pix_token_readout: TSW must be at least 2 and AMPW at least 1");
      end
   endgenerate

   logic [NPIX-1:0] mask;
   logic [AW-1:0]   ptr;
   logic            cur_hit, clr;
   logic [TSW-1:0]  rd_ts;
   logic [AMPW-1:0] rd_amp;

   pxro_stamp #(.TSW(TSW), .INVERT(TS_INVERT)) u_stamp (
      .clk (clk),
      .rst (rst),
      .ts  (ts_now)
   );

   pxro_mask #(.NBIT(NPIX)) u_mask (
      .clk       (clk),
      .rst       (rst),
      .shift_en  (shift_en),
      .shift_in  (shift_in),
      .mask      (mask),
      .shift_out (shift_out)
   );

   pxro_store #(.NPIX(NPIX), .AW(AW), .TSW(TSW), .AMPW(AMPW)) u_store (
      .clk       (clk),
      .rst       (rst),
      .accept_en (!busy),
      .hit_stb   (hit_stb),
      .hit_idx   ({hit_row, hit_col}),
      .hit_amp   (hit_amp),
      .ts        (ts_now),
      .inj_pulse (inj_pulse),
      .inj_amp   (inj_amp),
      .mask      (mask),
      .rd_idx    (ptr),
      .rd_clr    (clr),
      .rd_hit    (cur_hit),
      .rd_ts     (rd_ts),
      .rd_amp    (rd_amp)
   );

   pxro_scan #(.NPIX(NPIX), .AW(AW)) u_scan (
      .clk       (clk),
      .rst       (rst),
      .start     (start),
      .cur_hit   (cur_hit),
      .out_ready (out_ready),
      .ptr       (ptr),
      .busy      (busy),
      .out_valid (out_valid),
      .clr       (clr),
      .done      (done)
   );

   assign out_word = {ptr[AW-1:CAW], ptr[CAW-1:0], rd_ts, rd_amp};

   AST_VALID_IN_FRAME: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> busy); // R5
   AST_WORD_STABLE: assert property (@(posedge clk) disable iff (rst)
      out_valid && !out_ready |=> $stable(out_word)); // R6

endmodule

// File: tb/test_pix_token_readout.sv
`timescale 1ns/1ps
module test_pix_token_readout;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        hit_stb = 1'b0;
   logic [5:0]  hit_row = '0, hit_col = '0;
   logic [7:0]  hit_amp = '0, inj_amp = '0;
   logic        inj_pulse = 1'b0, shift_en = 1'b0, shift_in = 1'b0;
   logic        shift_out, start = 1'b0, busy, done, out_valid;
   logic        out_ready = 1'b1;
   logic [24:0] out_word;
   logic [4:0]  ts_now;

   int errors = 0;
   int checks = 0;
   logic [24:0] got [16];

   always #10 clk = ~clk;

   pix_token_readout i_pix_token_readout (
      .clk(clk), .rst(rst), .hit_stb(hit_stb), .hit_row(hit_row), .hit_col(hit_col),
      .hit_amp(hit_amp), .inj_pulse(inj_pulse), .inj_amp(inj_amp), .shift_en(shift_en),
      .shift_in(shift_in), .shift_out(shift_out), .start(start), .busy(busy), .done(done),
      .out_valid(out_valid), .out_ready(out_ready), .out_word(out_word), .ts_now(ts_now)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic int ts_to_bin(input logic [4:0] t);
      logic [4:0] g = ~t;
      logic [4:0] b;
      b[4] = g[4];
      for (int i = 3; i >= 0; i--) b[i] = b[i+1] ^ g[i];
      return int'(b);
   endfunction

   function automatic logic [24:0] mk_word(input int r, input int c, input logic [4:0] t,
                                           input logic [7:0] a);
      return {6'(r), 6'(c), t, a};
   endfunction

   function automatic bit pat(input int s);
      return ((s * 37) % 11) < 3;
   endfunction

   task automatic strobe(input int r, input int c, input logic [7:0] a, output logic [4:0] t);
      @(negedge clk);
      hit_stb = 1'b1; hit_row = 6'(r); hit_col = 6'(c); hit_amp = a;
      t = ts_now;
      @(negedge clk);
      hit_stb = 1'b0;
   endtask

   task automatic run_frame(output int n_words, output int n_cyc);
      n_words = 0;
      @(negedge clk); start = 1'b1;
      @(negedge clk); start = 1'b0;
      n_cyc = 0;
      while (!done && n_cyc < 5000) begin
         if (out_valid && out_ready) begin
            if (n_words < 16) got[n_words] = out_word;
            n_words++;
         end
         @(negedge clk);
         n_cyc++;
      end
   endtask

   task automatic t_reset;
      repeat (3) @(negedge clk);
      chk(!busy && !done && !out_valid, "R1", "idle outputs in reset",
          {busy, done, out_valid}, 0);
      chk(ts_now == 5'b11111, "R1", "stamp in reset", ts_now, 5'b11111);
      rst = 1'b0;
      @(negedge clk);
      chk(!busy && !out_valid, "R1", "idle after reset", {busy, out_valid}, 0);
   endtask

   task automatic t_gray;
      logic [4:0] prev;
      @(negedge clk);
      prev = ts_now;
      for (int i = 0; i < 40; i++) begin
         @(negedge clk);
         chk(ts_to_bin(ts_now) == ((ts_to_bin(prev) + 1) % 32), "R2", "stamp step",
             ts_to_bin(ts_now), (ts_to_bin(prev) + 1) % 32);
         chk($countones(ts_now ^ prev) == 1, "R2", "one bit change", ts_now ^ prev, 1);
         prev = ts_now;
      end
   endtask

   task automatic t_empty;
      int nw, nc;
      run_frame(nw, nc);
      chk(nc == 4096, "R5", "empty frame length", nc, 4096);
      chk(nw == 0, "R5", "empty frame words", nw, 0);
      @(negedge clk);
      chk(!done && !busy, "R5", "done is one cycle", {done, busy}, 0);
   endtask

   task automatic t_order;
      int nw, nc;
      logic [4:0] ta, tb, tc, td;
      strobe(3, 10, 8'h31, ta);
      repeat (2) @(negedge clk);
      strobe(0, 5, 8'h42, tb);
      strobe(63, 63, 8'hFE, tc);
      strobe(3, 2, 8'h07, td);
      run_frame(nw, nc);
      chk(nw == 4, "R5", "hit count", nw, 4);
      chk(got[0] == mk_word(0, 5, tb, 8'h42), "R4", "word 0 (row0 col5)", got[0], mk_word(0, 5, tb, 8'h42));
      chk(got[1] == mk_word(3, 2, td, 8'h07), "R5", "raster word 1", got[1], mk_word(3, 2, td, 8'h07));
      chk(got[2] == mk_word(3, 10, ta, 8'h31), "R3", "stamp of word 2", got[2], mk_word(3, 10, ta, 8'h31));
      chk(got[3] == mk_word(63, 63, tc, 8'hFE), "R4", "last pixel word", got[3], mk_word(63, 63, tc, 8'hFE));
      chk(nc == 4096, "R5", "frame length with ready high", nc, 4096);
   endtask

   task automatic t_backpressure;
      int nw, nc, w;
      logic [4:0] t;
      logic [24:0] held;
      out_ready = 1'b0;
      strobe(5, 9, 8'h3C, t);
      @(negedge clk); start = 1'b1;
      @(negedge clk); start = 1'b0;
      w = 0;
      while (!out_valid && w < 5000) begin @(negedge clk); w++; end
      held = out_word;
      chk(held == mk_word(5, 9, t, 8'h3C), "R6", "held word", held, mk_word(5, 9, t, 8'h3C));
      for (int i = 0; i < 8; i++) begin
         @(negedge clk);
         chk(out_valid && out_word == held, "R6", "token held while stalled", out_word, held);
      end
      out_ready = 1'b1;
      @(negedge clk);
      chk(!out_valid, "R7", "valid drops after accept", out_valid, 0);
      w = 0;
      while (!done && w < 5000) begin @(negedge clk); w++; end
      run_frame(nw, nc);
      chk(nw == 0, "R7", "accepted pixel not reported again", nw, 0);
   endtask

   task automatic t_busy_ignore;
      int nw, w;
      logic [4:0] t, tdum;
      strobe(10, 10, 8'h55, t);
      @(negedge clk); start = 1'b1;
      @(negedge clk); start = 1'b0;
      @(negedge clk);
      hit_stb = 1'b1; hit_row = 6'd40; hit_col = 6'd0; hit_amp = 8'h66;
      inj_pulse = 1'b1; inj_amp = 8'h77;
      @(negedge clk);
      hit_stb = 1'b0; inj_pulse = 1'b0;
      nw = 0; w = 0;
      while (!done && w < 5000) begin
         if (out_valid) begin
            if (nw < 16) got[nw] = out_word;
            nw++;
         end
         @(negedge clk); w++;
      end
      chk(nw == 1, "R8", "only pre-frame hit read", nw, 1);
      chk(got[0] == mk_word(10, 10, t, 8'h55), "R8", "pre-frame word", got[0], mk_word(10, 10, t, 8'h55));
      run_frame(nw, w);
      chk(nw == 0, "R8", "busy-time strobe not latched", nw, 0);
      tdum = t;
   endtask

   task automatic t_dup;
      int nw, nc;
      logic [4:0] t1, t2;
      strobe(2, 3, 8'h11, t1);
      repeat (3) @(negedge clk);
      strobe(2, 3, 8'h22, t2);
      run_frame(nw, nc);
      chk(nw == 1, "R9", "one record for repeated hit", nw, 1);
      chk(got[0] == mk_word(2, 3, t1, 8'h11), "R9", "first hit kept", got[0], mk_word(2, 3, t1, 8'h11));
      chk(t1 != t2, "R9", "stamps differ", t2, t1);
   endtask

   task automatic t_shift;
      int bad, first_s;
      @(negedge clk);
      for (int s = 0; s < 4096; s++) begin
         shift_en = 1'b1; shift_in = pat(s);
         @(negedge clk);
      end
      shift_en = 1'b0;
      repeat (3) @(negedge clk);
      chk(shift_out == pat(0), "R10", "top bit held with enable low", shift_out, pat(0));
      bad = 0; first_s = -1;
      for (int s = 0; s < 4096; s++) begin
         if (shift_out != pat(s)) begin
            bad++;
            if (first_s < 0) first_s = s;
         end
         shift_en = 1'b1;
         shift_in = ((4095 - s) == 7) || ((4095 - s) == 200) || ((4095 - s) == 4095);
         @(negedge clk);
      end
      shift_en = 1'b0;
      chk(bad == 0, "R10", "readback mismatches", bad, 0);
   endtask

   task automatic t_inject;
      int nw, nc;
      logic [4:0] t;
      @(negedge clk);
      inj_pulse = 1'b1; inj_amp = 8'hA5;
      t = ts_now;
      @(negedge clk);
      inj_pulse = 1'b0;
      run_frame(nw, nc);
      chk(nw == 3, "R11", "injected pixel count", nw, 3);
      chk(got[0] == mk_word(0, 7, t, 8'hA5), "R11", "pixel 7", got[0], mk_word(0, 7, t, 8'hA5));
      chk(got[1] == mk_word(3, 8, t, 8'hA5), "R11", "pixel 200", got[1], mk_word(3, 8, t, 8'hA5));
      chk(got[2] == mk_word(63, 63, t, 8'hA5), "R11", "pixel 4095", got[2], mk_word(63, 63, t, 8'hA5));
   endtask

   bit finished = 1'b0;

   initial begin
      t_reset;
      t_gray;
      t_empty;
      t_order;
      t_backpressure;
      t_busy_ignore;
      t_dup;
      t_shift;
      t_inject;
      finished = 1'b1;
   end

   initial begin
      fork
         wait (finished);
         begin
            repeat (200000) @(posedge clk);
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
         end
      join_any
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule